// File: doc/BRIEF.md
# GPIO Port with Per-Pin Interrupt Detection

This block is a 32-pin general-purpose I/O port. Software controls it through a synchronous register bus with a word index. For each pin, software sets the driven level and chooses whether the pin is an input or an output. Software can also read back the synchronised level of every pin. Every pin feeds an interrupt detector with four trigger choices. A hit sets a sticky pending bit. Software clears that bit by writing a one to it. Each pending bit is gated by its own enable bit.

The port has three interrupt request lines. One covers the lower sixteen pins, one covers the upper sixteen, and one covers all 32. A host reaches the registers through `bus_addr`, which is the byte offset divided by four. Writes take effect on the clock edge where `bus_wen` is high. Read data is registered and appears on the cycle after the index is presented.

Top module: `gpio_irq_port`

## Requirements
- R1: After synchronous reset, every register reads zero, `pad_oe` and `pad_out` are zero, and all three request outputs are low.
- R2: Word indices are 0 for output data and 1 for direction. A write to either index appears on `pad_out` or `pad_oe` after that edge. A direction bit of 1 enables the pin's output driver.
- R3: Index 2 reads the pad levels after a two-flop synchroniser, whatever the direction bits are. A read issued one cycle after a pad change still returns the old level. A read issued two cycles after the change returns the new level.
- R4: Index 3 holds the 2-bit trigger fields of pins 0–15 and index 4 holds those of pins 16–31. The field of pin n sits at bits 2*(n mod 16)+1 down to 2*(n mod 16). Both indices read back what was written.
- R5: Trigger code 10 sets a pin's pending bit on a low-to-high change of its synchronised level, and only on that change.
- R6: Trigger code 11 sets a pin's pending bit on a high-to-low change of its synchronised level, and only on that change.
- R7: Trigger codes 00 (low level) and 01 (high level) set the pending bit on every cycle the level holds. A clear therefore has no lasting effect until the level goes away.
- R8: Index 6 is the pending register. Writing a 1 to a bit clears it. Writing a 0 leaves it unchanged.
- R9: If a trigger hit and a clear write reach the same bit in the same cycle, the bit stays set.
- R10: `irq_lo` is the OR of pending-and-enabled bits 0–15, and `irq_hi` is the same for bits 16–31. `irq_any` is the OR of both. Each output is registered and follows the pending and enable bits one cycle later.
- R11: Index 5 holds the enable bits, where 1 means enabled. A pending bit whose enable is 0 raises no request.
- R12: Writes to index 2 and to index 7 have no effect on any register. Index 7 reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wen | input | 1 | Write strobe |
| bus_addr | input | 3 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| pad_in | input | 32 | Pad levels from the pins |
| pad_out | output | 32 | Level to drive on each pin |
| pad_oe | output | 32 | Output enable for each pin |
| irq_lo | output | 1 | Request for pins 0–15 |
| irq_hi | output | 1 | Request for pins 16–31 |
| irq_any | output | 1 | Request for all pins |

## Verification
A trigger hit and a software clear can hit the same pending bit on one edge. The bench provokes this by raising a rising-edge pin and timing the clear write two cycles later, which is exactly the edge on which the synchronised transition sets the bit. A read of the pending register afterwards must still show the bit set. A held high level combined with a clear covers the same collision in the level modes.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  typedef enum logic [1:0] {
    TRIG_LOW  = 2'b00,
    TRIG_HIGH = 2'b01,
    TRIG_RISE = 2'b10,
    TRIG_FALL = 2'b11
  } trig_mode_e;

  typedef enum logic [2:0] {
    REG_DOUT = 3'd0,
    REG_DIR  = 3'd1,
    REG_PAD  = 3'd2,
    REG_CFGL = 3'd3,
    REG_CFGH = 3'd4,
    REG_MASK = 3'd5,
    REG_STAT = 3'd6
  } reg_idx_e;

endpackage

// File: rtl/gpio_sync_bank.sv
module gpio_sync_bank #(
  parameter int WIDTH  = 32,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] sync_q,
  output logic [WIDTH-1:0] prev_q
);

  logic [WIDTH-1:0] stage_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stage_q[i] <= '0;
      prev_q <= '0;
    end else begin
      stage_q[0] <= din;
      for (int i = 1; i < STAGES; i++) stage_q[i] <= stage_q[i-1];
      prev_q <= stage_q[STAGES-1];
    end
  end

  assign sync_q = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_trig_detect.sv
module gpio_trig_detect
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32
) (
  input  logic [2*PINS-1:0] cfg,
  input  logic [PINS-1:0]   cur,
  input  logic [PINS-1:0]   prev,
  output logic [PINS-1:0]   hit
);

  for (genvar n = 0; n < PINS; n++) begin : g_pin
    trig_mode_e mode;
    assign mode = trig_mode_e'(cfg[2*n +: 2]);
    always_comb begin
      case (mode)
        TRIG_LOW:  hit[n] = ~cur[n];
        TRIG_HIGH: hit[n] = cur[n];
        TRIG_RISE: hit[n] = cur[n] & ~prev[n];
        TRIG_FALL: hit[n] = ~cur[n] & prev[n];
        default:   hit[n] = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/gpio_irq_status.sv
module gpio_irq_status #(
  parameter int PINS = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [PINS-1:0] set_vec,
  input  logic [PINS-1:0] clr_vec,
  input  logic [PINS-1:0] mask,
  output logic [PINS-1:0] stat_q,
  output logic            irq_lo,
  output logic            irq_hi,
  output logic            irq_any
);

  localparam int HALF = PINS / 2;

  logic [PINS-1:0] live;
  assign live = stat_q & mask;

  always_ff @(posedge clk) begin
    if (rst) begin
      stat_q  <= '0;
      irq_lo  <= 1'b0;
      irq_hi  <= 1'b0;
      irq_any <= 1'b0;
    end else begin
      stat_q  <= (stat_q & ~clr_vec) | set_vec;
      irq_lo  <= |live[HALF-1:0];
      irq_hi  <= |live[PINS-1:HALF];
      irq_any <= |live;
    end
  end

endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port
  import gpio_irq_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wen,
  input  logic [2:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] pad_in,
  output logic [DATA_W-1:0] pad_out,
  output logic [DATA_W-1:0] pad_oe,
  output logic              irq_lo,
  output logic              irq_hi,
  output logic              irq_any
);

  localparam int PINS = DATA_W;

  logic [DATA_W-1:0] dout_q, dir_q, cfgl_q, cfgh_q, mask_q;
  logic [PINS-1:0]   pad_sync, pad_prev, hit_vec, clr_vec, stat_vec;

  gpio_sync_bank #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) sync_i (
    .clk    (clk),
    .rst    (rst),
    .din    (pad_in),
    .sync_q (pad_sync),
    .prev_q (pad_prev)
  );

  gpio_trig_detect #(.PINS(PINS)) det_i (
    .cfg  ({cfgh_q, cfgl_q}),
    .cur  (pad_sync),
    .prev (pad_prev),
    .hit  (hit_vec)
  );

  assign clr_vec = (bus_wen && bus_addr == REG_STAT) ? bus_wdata : '0;

  gpio_irq_status #(.PINS(PINS)) stat_i (
    .clk     (clk),
    .rst     (rst),
    .set_vec (hit_vec),
    .clr_vec (clr_vec),
    .mask    (mask_q),
    .stat_q  (stat_vec),
    .irq_lo  (irq_lo),
    .irq_hi  (irq_hi),
    .irq_any (irq_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      dout_q <= '0;
      dir_q  <= '0;
      cfgl_q <= '0;
      cfgh_q <= '0;
      mask_q <= '0;
    end else if (bus_wen) begin
      case (bus_addr)
        REG_DOUT: dout_q <= bus_wdata;
        REG_DIR:  dir_q  <= bus_wdata;
        REG_CFGL: cfgl_q <= bus_wdata;
        REG_CFGH: cfgh_q <= bus_wdata;
        REG_MASK: mask_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        REG_DOUT: bus_rdata <= dout_q;
        REG_DIR:  bus_rdata <= dir_q;
        REG_PAD:  bus_rdata <= pad_sync;
        REG_CFGL: bus_rdata <= cfgl_q;
        REG_CFGH: bus_rdata <= cfgh_q;
        REG_MASK: bus_rdata <= mask_q;
        REG_STAT: bus_rdata <= stat_vec;
        default:  bus_rdata <= '0;
      endcase
    end
  end

  assign pad_out = dout_q;
  assign pad_oe  = dir_q;

endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int PINS = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            bus_wen,
  input logic [2:0]      bus_addr,
  input logic [PINS-1:0] bus_wdata,
  input logic [PINS-1:0] pad_out,
  input logic [PINS-1:0] pad_oe,
  input logic            irq_lo,
  input logic            irq_hi,
  input logic            irq_any,
  input logic [PINS-1:0] stat_vec,
  input logic [PINS-1:0] mask_q,
  input logic [PINS-1:0] hit_vec
);

  localparam int HALF = PINS / 2;

  p_reset_quiet_r1: assert property (@(posedge clk)
    rst |=> (pad_oe == '0 && pad_out == '0 && !irq_any));

  p_oe_follows_dir_r2: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == REG_DIR) |=> (pad_oe == $past(bus_wdata)));

  p_w1c_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (bus_wen && bus_addr == REG_STAT) |=>
      ((stat_vec & $past(bus_wdata & ~hit_vec)) == '0));

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    (hit_vec != '0) |=> ((stat_vec & $past(hit_vec)) == $past(hit_vec)));

  p_any_is_or_r10: assert property (@(posedge clk) disable iff (rst)
    irq_any == (irq_lo | irq_hi));

  p_mask_gates_lo_r11: assert property (@(posedge clk) disable iff (rst)
    ((stat_vec[HALF-1:0] & mask_q[HALF-1:0]) == '0) |=> !irq_lo);

  p_mask_gates_hi_r11: assert property (@(posedge clk) disable iff (rst)
    ((stat_vec[PINS-1:HALF] & mask_q[PINS-1:HALF]) == '0) |=> !irq_hi);

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.PINS(DATA_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .bus_wen   (bus_wen),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .pad_out   (pad_out),
  .pad_oe    (pad_oe),
  .irq_lo    (irq_lo),
  .irq_hi    (irq_hi),
  .irq_any   (irq_any),
  .stat_vec  (stat_vec),
  .mask_q    (mask_q),
  .hit_vec   (hit_vec)
);

// File: tb/gpio_irq_port_tb_top.sv
`timescale 1ns/1ps
module gpio_irq_port_tb_top;

  typedef struct {
    logic [31:0] exp;
    string       req;
  } sb_item_t;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wen = 1'b0;
  logic [2:0]  bus_addr = 3'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [31:0] pad_in = '0;
  logic [31:0] pad_out, pad_oe;
  logic        irq_lo, irq_hi, irq_any;

  int checks = 0;
  int errors = 0;
  logic rd_issue = 1'b0;
  logic rd_issue_d = 1'b0;
  sb_item_t exp_q[$];

  always #2.5 clk = ~clk;

  gpio_irq_port dut_i (
    .clk(clk), .rst(rst), .bus_wen(bus_wen), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
    .pad_out(pad_out), .pad_oe(pad_oe), .irq_lo(irq_lo), .irq_hi(irq_hi),
    .irq_any(irq_any)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    bus_addr = a; bus_wdata = d; bus_wen = 1'b1;
    @(negedge clk);
    bus_wen = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [31:0] e, input string r);
    exp_q.push_back('{exp: e, req: r});
    bus_addr = a; rd_issue = 1'b1;
    @(negedge clk);
    rd_issue = 1'b0;
  endtask

  always @(posedge clk) rd_issue_d <= rd_issue;

  initial begin
    sb_item_t it;
    forever begin
      @(negedge clk);
      if (rd_issue_d) begin
        if (exp_q.size() == 0) begin
          chk("scoreboard underflow", 32'd1, 32'd0);
        end else begin
          it = exp_q.pop_front();
          chk(it.req, bus_rdata, it.exp);
        end
      end
    end
  end

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    tick(4);
    rst = 1'b0;
    // R1 reset state
    chk("R1 pad_oe", pad_oe, 32'h0);
    chk("R1 pad_out", pad_out, 32'h0);
    chk("R1 irq_any", {31'h0, irq_any}, 32'h0);
    rd(3'd0, 32'h0, "R1 dout");
    rd(3'd1, 32'h0, "R1 dir");
    rd(3'd3, 32'h0, "R1 cfg low");
    rd(3'd4, 32'h0, "R1 cfg high");
    rd(3'd5, 32'h0, "R1 mask");
    rd(3'd7, 32'h0, "R12 unmapped read");

    // all pins rising, pin 20 falling (field bits 9:8 of high cfg)
    wr(3'd3, 32'hAAAAAAAA);
    wr(3'd4, 32'hAAAAABAA);
    rd(3'd4, 32'hAAAAABAA, "R4 cfg high readback");
    wr(3'd6, 32'hFFFFFFFF);
    rd(3'd6, 32'h0, "R8 clear all");

    // R2 data and direction
    wr(3'd0, 32'hA5A50F0F);
    wr(3'd1, 32'hFFFF0000);
    chk("R2 pad_out", pad_out, 32'hA5A50F0F);
    chk("R2 pad_oe", pad_oe, 32'hFFFF0000);
    rd(3'd1, 32'hFFFF0000, "R2 dir readback");

    // R12 writes to pad index and unmapped index ignored
    wr(3'd2, 32'hFFFFFFFF);
    wr(3'd7, 32'hFFFFFFFF);
    rd(3'd0, 32'hA5A50F0F, "R12 dout untouched");
    rd(3'd7, 32'h0, "R12 unmapped still zero");
    rd(3'd2, 32'h0, "R12 pad unaffected");

    // R3 synchroniser latency, regardless of direction
    pad_in = 32'h12345678;
    tick(1);
    rd(3'd2, 32'h0, "R3 one cycle old");
    rd(3'd2, 32'h12345678, "R3 two cycles new");
    pad_in = 32'h0;
    tick(4);
    wr(3'd6, 32'hFFFFFFFF);
    rd(3'd6, 32'h0, "R8 clear after pad activity");

    // R5 rising on pin 3, pin 20 (falling) ignores rise
    pad_in = 32'h00100008;
    tick(4);
    rd(3'd6, 32'h00000008, "R5 rise sets pin3, R6 rise ignored on pin20");
    pad_in = 32'h0;
    tick(4);
    rd(3'd6, 32'h00100008, "R6 fall sets pin20, R4 upper field");
    chk("R11 masked irq_lo", {31'h0, irq_lo}, 32'h0);
    chk("R11 masked irq_hi", {31'h0, irq_hi}, 32'h0);

    // R10 / R11 request outputs
    wr(3'd5, 32'h00000008);
    tick(1);
    chk("R10 irq_lo", {31'h0, irq_lo}, 32'h1);
    chk("R11 irq_hi masked", {31'h0, irq_hi}, 32'h0);
    chk("R10 irq_any", {31'h0, irq_any}, 32'h1);
    wr(3'd5, 32'h00100008);
    tick(1);
    chk("R10 irq_hi", {31'h0, irq_hi}, 32'h1);

    // R8 write-one-to-clear with zero bits untouched
    wr(3'd6, 32'h00000008);
    tick(1);
    chk("R8 irq_lo after clear", {31'h0, irq_lo}, 32'h0);
    chk("R8 irq_hi kept", {31'h0, irq_hi}, 32'h1);
    rd(3'd6, 32'h00100000, "R8 zero bits no effect");
    wr(3'd6, 32'h00100000);
    tick(1);
    chk("R10 irq_any low", {31'h0, irq_any}, 32'h0);

    // R7 high level on pin 5 (bits 11:10 = 01)
    wr(3'd3, 32'hAAAAA6AA);
    pad_in = 32'h00000020;
    tick(4);
    wr(3'd6, 32'h00000020);
    rd(3'd6, 32'h00000020, "R7 level held resets bit");
    pad_in = 32'h0;
    tick(4);
    wr(3'd6, 32'h00000020);
    rd(3'd6, 32'h0, "R7 clear after level gone");

    // R9 set and clear in the same cycle on pin 3 (rising)
    pad_in = 32'h00000008;
    tick(2);
    wr(3'd6, 32'h00000008);
    rd(3'd6, 32'h00000008, "R9 set wins");
    wr(3'd6, 32'h00000008);
    rd(3'd6, 32'h0, "R9 later clear works");

    tick(3);
    chk("scoreboard drained", exp_q.size(), 32'd0);
    finish_run();
  end

endmodule